// File: doc/BRIEF.md
# Branch Target Generator for Absolute, Long and Indexed Jumps

This block sits beside the decode stage of an 8-bit microcontroller core and works out where control goes next for the unconditional branch forms that carry or compute a full or partial address. Each cycle the decoder may raise a request. With the request it presents the following inputs:
- the opcode byte;
- up to two operand bytes;
- the address of the instruction that follows the branch;
- the accumulator;
- the 16-bit data pointer.

One clock later the block presents a one-cycle valid strobe. With the strobe come a taken flag, the branch target, a flag that asks the stack logic to push a return address, and that return address.

There are three ways to form a target. A short-range (page) branch keeps the top five address bits of the following instruction's address. It fills the low eleven bits from the opcode's three top bits and the first operand byte, so it cannot leave the current 2K page. A long branch takes a full 16-bit address from the two operand bytes, high byte first. The indexed jump adds the accumulator, as an unsigned value, to the data pointer, and the sum wraps at 64K. Any other opcode leaves the taken flag low.

Top module: `jump_target_gen`

## Requirements
- R1: While `rst_n` is low, and after it, until the first request, `out_vld`, `taken`, `push_ret`, `target` and `ret_addr` are all zero.
- R2: `out_vld` is high in exactly the cycle after each cycle with `req` high, and low otherwise. When `req` is low, `taken`, `target`, `push_ret` and `ret_addr` keep their values whatever the other inputs do.
- R3: A page jump has an opcode whose low five bits are 00001 and whose bits 7..5 are any value. It gives `taken`=1 and `push_ret`=0. Its `target` is `{next_pc[15:11], opc[7:5], arg1}`.
- R4: A page call has an opcode whose low five bits are 10001. It gives `taken`=1 and `push_ret`=1, with the same target as R3. Example: opcode F1h and operand A6h with `next_pc`=1026h give target 17A6h.
- R5: The five page bits come from `next_pc` and not from the branch's own address. For a page branch at 0FFEh, `next_pc` is 1000h, so the target lies in the page that starts at 1000h.
- R6: A long jump has opcode 02h. It gives `taken`=1, `push_ret`=0 and `target` = `{arg1, arg2}`, with `arg1` as the high byte.
- R7: A long call has opcode 12h. It gives `taken`=1, `push_ret`=1 and `target` = `{arg1, arg2}`.
- R8: The indexed jump has opcode 73h. It gives `taken`=1, `push_ret`=0 and `target` = (`dptr` + `acc`) mod 65536, with `acc` taken as unsigned.
- R9: Any other opcode gives `taken`=0, `push_ret`=0, `target`=0 and `ret_addr`=0.
- R10: For both call forms, `ret_addr` equals `next_pc`. For every non-call opcode it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Decode request; the inputs below are sampled when it is high |
| opc | input | 8 | Opcode byte |
| arg1 | input | 8 | First operand byte |
| arg2 | input | 8 | Second operand byte |
| next_pc | input | 16 | Address of the instruction after the branch |
| acc | input | 8 | Accumulator (unsigned index) |
| dptr | input | 16 | Data pointer (indexed base) |
| out_vld | output | 1 | One-cycle strobe, one clock after `req` |
| taken | output | 1 | Opcode is one of the five recognised branches |
| target | output | 16 | Branch target address |
| push_ret | output | 1 | Branch is a call |
| ret_addr | output | 16 | Return address to push |

## Verification
The bench targets four mistakes:
- A page branch placed in the last two bytes of a page. A design that took the page bits from the branch's own address would land one page too low.
- An indexed jump whose sum crosses FFFFh or whose accumulator has bit 7 set. A design that carried too many bits or sign-extended the accumulator would give a wrong address.
- Opcodes one bit away from the recognised ones, such as 03h, 13h, 72h and x0001 patterns with bit 4 flipped into other positions. A loose decoder would call these taken or flag them as calls.
- Idle cycles that change every input. A design that loaded its result registers without the request would change its outputs during them.

// File: rtl/jtg_pkg.sv
package jtg_pkg;
  localparam int BYTE_W  = 8;
  localparam int HI_W    = 3;
  localparam int PAGE_W  = BYTE_W + HI_W;
  localparam int LOW_W   = BYTE_W - HI_W;

  localparam logic [LOW_W-1:0]  PAGE_JMP_LO  = 5'b00001;
  localparam logic [LOW_W-1:0]  PAGE_CALL_LO = 5'b10001;
  localparam logic [BYTE_W-1:0] LONG_JMP_OPC  = 8'h02;
  localparam logic [BYTE_W-1:0] LONG_CALL_OPC = 8'h12;
  localparam logic [BYTE_W-1:0] IDX_JMP_OPC   = 8'h73;

  typedef enum logic [2:0] {
    BK_NONE, BK_PJMP, BK_PCALL, BK_LJMP, BK_LCALL, BK_IDX
  } br_kind_e;

  function automatic logic kind_is_call(input br_kind_e k);
    return (k == BK_PCALL) || (k == BK_LCALL);
  endfunction
endpackage

// File: rtl/jtg_decode.sv
module jtg_decode
  import jtg_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  output br_kind_e          kind
);
  always_comb begin
    kind = BK_NONE;
    if (opc[LOW_W-1:0] == PAGE_JMP_LO)       kind = BK_PJMP;
    else if (opc[LOW_W-1:0] == PAGE_CALL_LO) kind = BK_PCALL;
    else if (opc == LONG_JMP_OPC)            kind = BK_LJMP;
    else if (opc == LONG_CALL_OPC)           kind = BK_LCALL;
    else if (opc == IDX_JMP_OPC)             kind = BK_IDX;
  end
endmodule

// File: rtl/jtg_addr.sv
module jtg_addr
  import jtg_pkg::*;
#(
  parameter int AW = 16
) (
  input  br_kind_e          kind,
  input  logic [BYTE_W-1:0] opc,
  input  logic [BYTE_W-1:0] arg1,
  input  logic [BYTE_W-1:0] arg2,
  input  logic [AW-1:0]     next_pc,
  input  logic [BYTE_W-1:0] acc,
  input  logic [AW-1:0]     dptr,
  output logic [AW-1:0]     tgt
);
  localparam int PG_HI_W = AW - PAGE_W;
  localparam int LONG_W  = 2 * BYTE_W;

  function automatic logic [AW-1:0] page_tgt(input logic [AW-1:0] pc,
                                             input logic [BYTE_W-1:0] op,
                                             input logic [BYTE_W-1:0] lo);
    return {pc[AW-1:PAGE_W], op[BYTE_W-1:LOW_W], lo};
  endfunction

  function automatic logic [AW-1:0] long_tgt(input logic [BYTE_W-1:0] hi,
                                             input logic [BYTE_W-1:0] lo);
    logic [LONG_W-1:0] w;
    w = {hi, lo};
    return AW'(w);
  endfunction

  function automatic logic [AW-1:0] idx_tgt(input logic [AW-1:0] base,
                                            input logic [BYTE_W-1:0] ofs);
    return base + {{(AW-BYTE_W){1'b0}}, ofs};
  endfunction

  if (PG_HI_W < 1) begin : g_bad_aw
    initial $error("AW must exceed the page field width");
  end

  always_comb begin
    unique case (kind)
      BK_PJMP, BK_PCALL: tgt = page_tgt(next_pc, opc, arg1);
      BK_LJMP, BK_LCALL: tgt = long_tgt(arg1, arg2);
      BK_IDX:            tgt = idx_tgt(dptr, acc);
      default:           tgt = '0;
    endcase
  end
endmodule

// File: rtl/jtg_outreg.sv
module jtg_outreg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          d_taken,
  input  logic [AW-1:0] d_target,
  input  logic          d_push,
  input  logic [AW-1:0] d_ret,
  output logic          q_vld,
  output logic          q_taken,
  output logic [AW-1:0] q_target,
  output logic          q_push,
  output logic [AW-1:0] q_ret
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld    <= 1'b0;
      q_taken  <= 1'b0;
      q_target <= '0;
      q_push   <= 1'b0;
      q_ret    <= '0;
    end else begin
      q_vld <= load;
      if (load) begin
        q_taken  <= d_taken;
        q_target <= d_target;
        q_push   <= d_push;
        q_ret    <= d_ret;
      end
    end
  end
endmodule

// File: rtl/jump_target_gen.sv
module jump_target_gen
  import jtg_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BYTE_W-1:0] opc,
  input  logic [BYTE_W-1:0] arg1,
  input  logic [BYTE_W-1:0] arg2,
  input  logic [AW-1:0]     next_pc,
  input  logic [BYTE_W-1:0] acc,
  input  logic [AW-1:0]     dptr,
  output logic              out_vld,
  output logic              taken,
  output logic [AW-1:0]     target,
  output logic              push_ret,
  output logic [AW-1:0]     ret_addr
);
  br_kind_e      dec_kind;
  logic          dec_taken;
  logic          dec_call;
  logic [AW-1:0] comb_target;
  logic [AW-1:0] comb_ret;

  jtg_decode u_dec (
    .opc  (opc),
    .kind (dec_kind)
  );

  jtg_addr #(.AW(AW)) u_addr (
    .kind    (dec_kind),
    .opc     (opc),
    .arg1    (arg1),
    .arg2    (arg2),
    .next_pc (next_pc),
    .acc     (acc),
    .dptr    (dptr),
    .tgt     (comb_target)
  );

  assign dec_taken = (dec_kind != BK_NONE);
  assign dec_call  = kind_is_call(dec_kind);
  assign comb_ret  = dec_call ? next_pc : '0;

  jtg_outreg #(.AW(AW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req),
    .d_taken  (dec_taken),
    .d_target (comb_target),
    .d_push   (dec_call),
    .d_ret    (comb_ret),
    .q_vld    (out_vld),
    .q_taken  (taken),
    .q_target (target),
    .q_push   (push_ret),
    .q_ret    (ret_addr)
  );
endmodule

// File: rtl/jtg_checker.sv
module jtg_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic [7:0]    opc,
  input logic [7:0]    arg1,
  input logic [7:0]    arg2,
  input logic [AW-1:0] next_pc,
  input logic [7:0]    acc,
  input logic [AW-1:0] dptr,
  input logic          out_vld,
  input logic          taken,
  input logic [AW-1:0] target,
  input logic          push_ret,
  input logic [AW-1:0] ret_addr
);
  logic past_known;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_known <= 1'b0;
    else        past_known <= 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_vld && !taken && !push_ret && target == '0 && ret_addr == '0); // R1
    end
  end

  AST_VLD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    past_known |-> (out_vld == $past(req))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && !$past(req)) |-> ($stable(target) && $stable(taken) && $stable(ret_addr) && $stable(push_ret))); // R2

  AST_PAGE_JMP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && out_vld && $past(opc[4:0]) == 5'b00001) |->
      (taken && !push_ret && target == {$past(next_pc[AW-1:11]), $past(opc[7:5]), $past(arg1)})); // R3

  AST_PAGE_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && out_vld && $past(opc[4:0]) == 5'b10001) |->
      (taken && push_ret && target == {$past(next_pc[AW-1:11]), $past(opc[7:5]), $past(arg1)})); // R4

  AST_LONG_JMP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && out_vld && $past(opc) == 8'h02) |->
      (taken && !push_ret && target == AW'({$past(arg1), $past(arg2)}))); // R6

  AST_LONG_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && out_vld && $past(opc) == 8'h12) |->
      (taken && push_ret && target == AW'({$past(arg1), $past(arg2)}))); // R7

  AST_IDX_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && out_vld && $past(opc) == 8'h73) |->
      (taken && !push_ret && target == AW'($past(dptr) + AW'($past(acc))))); // R8

  AST_OTHER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && out_vld && $past(opc[4:0]) != 5'b00001 && $past(opc[4:0]) != 5'b10001 &&
     $past(opc) != 8'h02 && $past(opc) != 8'h12 && $past(opc) != 8'h73) |->
      (!taken && !push_ret && target == '0 && ret_addr == '0)); // R9

  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (past_known && out_vld) |-> (push_ret ? (ret_addr == $past(next_pc)) : (ret_addr == '0))); // R10
endmodule

bind jump_target_gen jtg_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .opc(opc), .arg1(arg1), .arg2(arg2),
  .next_pc(next_pc), .acc(acc), .dptr(dptr), .out_vld(out_vld), .taken(taken),
  .target(target), .push_ret(push_ret), .ret_addr(ret_addr)
);

// File: tb/jump_target_gen_tb_top.sv
module jump_target_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  opc = '0, arg1 = '0, arg2 = '0, acc = '0;
  logic [15:0] next_pc = '0, dptr = '0;
  logic        out_vld, taken, push_ret;
  logic [15:0] target, ret_addr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jump_target_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .opc(opc), .arg1(arg1), .arg2(arg2),
    .next_pc(next_pc), .acc(acc), .dptr(dptr), .out_vld(out_vld), .taken(taken),
    .target(target), .push_ret(push_ret), .ret_addr(ret_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected-value model, written from the requirements
  function automatic int cls(input logic [7:0] o); // 0 none,1 pjmp,2 pcall,3 ljmp,4 lcall,5 idx
    if ((o & 8'h1F) == 8'h01) return 1;
    if ((o & 8'h1F) == 8'h11) return 2;
    if (o == 8'h02) return 3;
    if (o == 8'h12) return 4;
    if (o == 8'h73) return 5;
    return 0;
  endfunction

  function automatic logic [15:0] exp_tgt(input logic [7:0] o, input logic [7:0] a1,
                                          input logic [7:0] a2, input logic [15:0] npc,
                                          input logic [7:0] ac, input logic [15:0] dp);
    int c = cls(o);
    int s;
    if (c == 1 || c == 2) return (npc & 16'hF800) | (16'(o >> 5) << 8) | 16'(a1);
    if (c == 3 || c == 4) return 16'(a1) * 16'd256 + 16'(a2);
    if (c == 5) begin
      s = int'(dp) + int'(ac);
      return 16'(s % 65536);
    end
    return 16'h0;
  endfunction

  task automatic run_op(input string tag, input logic [7:0] o, input logic [7:0] a1,
                        input logic [7:0] a2, input logic [15:0] npc,
                        input logic [7:0] ac, input logic [15:0] dp);
    int c = cls(o);
    bit call = (c == 2 || c == 4);
    @(negedge clk);
    opc = o; arg1 = a1; arg2 = a2; next_pc = npc; acc = ac; dptr = dp; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R2 vld"}, 32'(out_vld), 32'd1);
    chk({tag, " taken"}, 32'(taken), 32'(c != 0));
    chk({tag, " target"}, 32'(target), 32'(exp_tgt(o, a1, a2, npc, ac, dp)));
    chk({tag, " R10 push"}, 32'(push_ret), 32'(call));
    chk({tag, " R10 ret"}, 32'(ret_addr), call ? 32'(npc) : 32'd0);
  endtask

  initial begin
    logic [15:0] t_hold;
    logic        k_hold;
    logic [15:0] r_hold;
    logic [7:0]  olist [10];
    olist = '{8'h01, 8'h11, 8'h02, 8'h12, 8'h73, 8'h03, 8'h13, 8'h72, 8'h00, 8'hA5};
    void'($urandom(32'h5EED_0042));
    #1;
    chk("R1 vld in reset", 32'(out_vld), 0);
    chk("R1 target in reset", 32'(target), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after reset", 32'(out_vld), 0);
    chk("R1 taken after reset", 32'(taken), 0);
    chk("R1 ret after reset", 32'(ret_addr), 0);

    run_op("R4 page call 17A6", 8'hF1, 8'hA6, 8'h55, 16'h1026, 8'h00, 16'h0000);
    chk("R4 target 17A6", 32'(target), 32'h17A6);
    run_op("R3 page jmp 0F46", 8'hE1, 8'h46, 8'h00, 16'h0902, 8'h11, 16'h2222);
    chk("R3 target 0F46", 32'(target), 32'h0F46);
    run_op("R5 page edge", 8'h01, 8'h00, 8'h00, 16'h1000, 8'h00, 16'h0000);
    chk("R5 target 1000", 32'(target), 32'h1000);
    run_op("R5 page call edge", 8'hF1, 8'hFF, 8'h00, 16'hF800, 8'h00, 16'h0000);
    chk("R5 target FFFF", 32'(target), 32'hFFFF);
    run_op("R6 long jmp", 8'h02, 8'h8A, 8'hF2, 16'h0003, 8'h00, 16'h0000);
    chk("R6 target 8AF2", 32'(target), 32'h8AF2);
    run_op("R7 long call", 8'h12, 8'h00, 8'h01, 16'hC003, 8'h00, 16'h0000);
    run_op("R8 idx wrap", 8'h73, 8'h00, 8'h00, 16'h0101, 8'h20, 16'hFFF0);
    chk("R8 wrap 0010", 32'(target), 32'h0010);
    run_op("R8 idx unsigned", 8'h73, 8'h00, 8'h00, 16'h0101, 8'h80, 16'h1000);
    chk("R8 unsigned 1080", 32'(target), 32'h1080);
    run_op("R9 near 03", 8'h03, 8'h12, 8'h34, 16'h4444, 8'h01, 16'h1111);
    run_op("R9 near 13", 8'h13, 8'h12, 8'h34, 16'h4444, 8'h01, 16'h1111);
    run_op("R9 near 72", 8'h72, 8'h12, 8'h34, 16'h4444, 8'h01, 16'h1111);
    run_op("R9 near 09", 8'h09, 8'h12, 8'h34, 16'h4444, 8'h01, 16'h1111);

    // R2 idle hold: change every input with req low
    run_op("R7 before hold", 8'h12, 8'hBE, 8'hEF, 16'h3210, 8'h00, 16'h0000);
    t_hold = target; k_hold = taken; r_hold = ret_addr;
    @(negedge clk);
    opc = 8'h73; arg1 = 8'h99; dptr = 16'h7777; acc = 8'h33; next_pc = 16'h0123;
    repeat (3) @(negedge clk);
    chk("R2 idle vld low", 32'(out_vld), 0);
    chk("R2 idle target held", 32'(target), 32'(t_hold));
    chk("R2 idle taken held", 32'(taken), 32'(k_hold));
    chk("R2 idle ret held", 32'(ret_addr), 32'(r_hold));

    for (int i = 0; i < 400; i++) begin
      logic [7:0] o;
      o = olist[$urandom_range(0, 9)];
      if (o == 8'h01 || o == 8'h11) o = o | 8'((($urandom_range(0, 7)) << 5));
      if (o == 8'hA5) o = 8'($urandom);
      run_op("R3-mix rand", o, 8'($urandom), 8'($urandom), 16'($urandom),
             8'($urandom), 16'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule